// File: doc/BRIEF.md
# Split Base-and-Bound Address Translator

This block turns effective addresses into physical addresses for a simple processor that keeps instructions and data in two separate segments. Each segment is described by a base and a length. Instruction fetches are relocated by the code segment. Loads and stores are relocated by the data segment. Both ports work at the same time and do not depend on each other. A translated address is the segment base added to the effective address. An effective address that lies outside the segment length is not passed on. It comes back as a fault with a zeroed address, and the processor's trap logic handles it from there.

The four segment registers are loaded through a small configuration port. A load is accepted only while the supervisor input is high. A load attempted in user mode leaves the registers unchanged and sets a sticky privilege-error output. Reset sets every base and length to zero. Every access therefore faults until supervisor software has set up the segments.

Top module: `seg_xlate`

## Requirements
- R1: While reset is asserted and after it is released, both response-valid outputs, both physical addresses, both fault flags and the privilege-error flag are zero.
- R2: A response appears exactly one clock after a request on the same port. In any cycle with no response, that port's physical address and fault outputs are zero.
- R3: A request inside its segment returns the base plus the zero-extended effective address, taken modulo 2^PW.
- R4: A request whose zero-extended effective address is greater than or equal to the segment length returns fault=1 with physical address zero. Address length-1 is still inside the segment.
- R5: Fetch requests (`fetch_req`/`fetch_ea`) use only the code base and code length.
- R6: Data requests (`data_req`/`data_ea`) use only the data base and data length. Both ports can be served in the same cycle.
- R7: With `cfg_we`=1 and `supervisor`=1, `cfg_wdata` is written to the register chosen by `cfg_sel`: 0 is code base, 1 is code length, 2 is data base, 3 is data length. The new value applies to requests from the next cycle on. A request in the same cycle as the write uses the old value.
- R8: A configuration write with `supervisor`=0 changes no register and sets `priv_err` from the next cycle on.
- R9: Once set, `priv_err` stays at 1 until reset, whatever writes follow.
- R10: After reset, and before any length has been written, every request on either port faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supervisor | input | 1 | High when the processor runs in supervisor mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 code base, 1 code length, 2 data base, 3 data length |
| cfg_wdata | input | PW (20) | Value to write |
| fetch_req | input | 1 | Instruction-fetch translation request |
| fetch_ea | input | AW (16) | Fetch effective address (program counter) |
| data_req | input | 1 | Load/store translation request |
| data_ea | input | AW (16) | Load/store effective address |
| fetch_rsp_valid | output | 1 | Fetch response valid |
| fetch_paddr | output | PW (20) | Fetch physical address (zero on fault) |
| fetch_fault | output | 1 | Fetch bounds violation |
| data_rsp_valid | output | 1 | Data response valid |
| data_paddr | output | PW (20) | Data physical address (zero on fault) |
| data_fault | output | 1 | Data bounds violation |
| priv_err | output | 1 | Sticky flag for a user-mode configuration write |

## Verification
A corrupted segment register shows up on the next request that uses that segment. It appears as a wrong address, or as a fault that is missing or spurious, one clock after that request. A broken write gate shows up in the same way on the first translation after the stray write, and `priv_err` shows it one clock after the write. The bench keeps its own copy of the four registers and a model of the privilege error. For every cycle it predicts both ports' outputs, so any difference is caught in the cycle it appears. Boundary addresses at length-1 and at length, a base that wraps, and writes that coincide with a request are driven on purpose.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  // Register select codes on the configuration port
  typedef enum logic [1:0] {
    SEL_CODE_BASE  = 2'd0,
    SEL_CODE_LIMIT = 2'd1,
    SEL_DATA_BASE  = 2'd2,
    SEL_DATA_LIMIT = 2'd3
  } seg_sel_e;

  localparam int NUM_SEG_REGS = 4;
  localparam int NUM_PORTS    = 2;

  // Port indices inside the translator array
  localparam int PORT_FETCH = 0;
  localparam int PORT_DATA  = 1;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_xlate_pkg::*;
#(
  parameter int PW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supervisor,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [PW-1:0] cfg_wdata,
  output logic [PW-1:0] code_base,
  output logic [PW-1:0] code_limit,
  output logic [PW-1:0] data_base,
  output logic [PW-1:0] data_limit,
  output logic          priv_err
);

  localparam int FLAT_W = NUM_SEG_REGS * PW;

  // Named events for the checks
  logic wr_accept;
  logic wr_reject;
  assign wr_accept = cfg_we &&  supervisor;
  assign wr_reject = cfg_we && !supervisor;

  logic [PW-1:0] seg_reg [NUM_SEG_REGS];

  for (genvar i = 0; i < NUM_SEG_REGS; i++) begin : g_reg
    logic hit;
    assign hit = wr_accept && (cfg_sel == 2'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)   seg_reg[i] <= '0;
      else if (hit) seg_reg[i] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         priv_err <= 1'b0;
    else if (wr_reject) priv_err <= 1'b1;
  end

  assign code_base  = seg_reg[SEL_CODE_BASE];
  assign code_limit = seg_reg[SEL_CODE_LIMIT];
  assign data_base  = seg_reg[SEL_DATA_BASE];
  assign data_limit = seg_reg[SEL_DATA_LIMIT];

  logic [FLAT_W-1:0] regs_flat;
  assign regs_flat = {seg_reg[3], seg_reg[2], seg_reg[1], seg_reg[0]};

  // R8: a rejected write leaves every register untouched
  p_reject_keeps_regs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> $stable(regs_flat));

  // R8: a rejected write raises the privilege error
  p_reject_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> priv_err);

  // R9: privilege error is sticky
  p_priv_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    priv_err |=> priv_err);

  // R7: with no write strobe nothing changes
  p_no_write_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(regs_flat));

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit #(
  parameter int AW = 16,
  parameter int PW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] ea,
  input  logic [PW-1:0] base,
  input  logic [PW-1:0] limit,
  output logic          rsp_valid,
  output logic [PW-1:0] paddr,
  output logic          fault
);

  function automatic logic [PW-1:0] widen(input logic [AW-1:0] a);
    return PW'(a);
  endfunction

  function automatic logic [PW-1:0] relocate(input logic [PW-1:0] b,
                                             input logic [AW-1:0] a);
    return b + widen(a);
  endfunction

  function automatic logic outside(input logic [PW-1:0] lim,
                                   input logic [AW-1:0] a);
    return widen(a) >= lim;
  endfunction

  // Named internal events
  logic          viol_now;
  logic [PW-1:0] sum_now;
  assign viol_now = req && outside(limit, ea);
  assign sum_now  = relocate(base, ea);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      paddr     <= '0;
      fault     <= 1'b0;
    end else begin
      rsp_valid <= req;
      fault     <= viol_now;
      paddr     <= (req && !viol_now) ? sum_now : '0;
    end
  end

  // R2: a response follows every request by one cycle
  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rsp_valid);

  // R2: no response without a request
  p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !rsp_valid);

  // R2: quiet outputs when idle
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!fault && paddr == '0));

  // R4: a fault always carries a zero address
  p_fault_zero_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (paddr == '0));

  // R10: a zero length rejects every address
  p_zero_limit_faults_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && limit == '0) |=> fault);

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supervisor,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [PW-1:0] cfg_wdata,
  input  logic          fetch_req,
  input  logic [AW-1:0] fetch_ea,
  input  logic          data_req,
  input  logic [AW-1:0] data_ea,
  output logic          fetch_rsp_valid,
  output logic [PW-1:0] fetch_paddr,
  output logic          fetch_fault,
  output logic          data_rsp_valid,
  output logic [PW-1:0] data_paddr,
  output logic          data_fault,
  output logic          priv_err
);

  logic [PW-1:0] code_base, code_limit, data_base, data_limit;

  seg_regfile #(.PW(PW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .supervisor (supervisor),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .code_base  (code_base),
    .code_limit (code_limit),
    .data_base  (data_base),
    .data_limit (data_limit),
    .priv_err   (priv_err)
  );

  // Per-port bundles, index 0 fetch, index 1 data
  logic          p_req   [NUM_PORTS];
  logic [AW-1:0] p_ea    [NUM_PORTS];
  logic [PW-1:0] p_base  [NUM_PORTS];
  logic [PW-1:0] p_limit [NUM_PORTS];
  logic          p_vld   [NUM_PORTS];
  logic [PW-1:0] p_pa    [NUM_PORTS];
  logic          p_flt   [NUM_PORTS];

  assign p_req[PORT_FETCH]   = fetch_req;
  assign p_ea[PORT_FETCH]    = fetch_ea;
  assign p_base[PORT_FETCH]  = code_base;
  assign p_limit[PORT_FETCH] = code_limit;
  assign p_req[PORT_DATA]    = data_req;
  assign p_ea[PORT_DATA]     = data_ea;
  assign p_base[PORT_DATA]   = data_base;
  assign p_limit[PORT_DATA]  = data_limit;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    seg_xlate_unit #(.AW(AW), .PW(PW)) u_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (p_req[g]),
      .ea        (p_ea[g]),
      .base      (p_base[g]),
      .limit     (p_limit[g]),
      .rsp_valid (p_vld[g]),
      .paddr     (p_pa[g]),
      .fault     (p_flt[g])
    );
  end

  assign fetch_rsp_valid = p_vld[PORT_FETCH];
  assign fetch_paddr     = p_pa[PORT_FETCH];
  assign fetch_fault     = p_flt[PORT_FETCH];
  assign data_rsp_valid  = p_vld[PORT_DATA];
  assign data_paddr      = p_pa[PORT_DATA];
  assign data_fault      = p_flt[PORT_DATA];

  // R5/R6: ports are independent; a response on one needs a request on that one
  p_fetch_own_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_req && data_req) |=> !fetch_rsp_valid);
  p_data_own_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_req && fetch_req) |=> !data_rsp_valid);

endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;

  localparam int AW = 16;
  localparam int PW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          supervisor = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [PW-1:0] cfg_wdata = '0;
  logic          fetch_req = 1'b0;
  logic [AW-1:0] fetch_ea = '0;
  logic          data_req = 1'b0;
  logic [AW-1:0] data_ea = '0;
  logic          fetch_rsp_valid, fetch_fault, data_rsp_valid, data_fault, priv_err;
  logic [PW-1:0] fetch_paddr, data_paddr;

  always #5 clk = ~clk;

  seg_xlate #(.AW(AW), .PW(PW)) u_dut (.*);

  int checks = 0;
  int failures = 0;

  typedef struct {
    bit           fv; bit ff; logic [PW-1:0] fpa;
    bit           dv; bit df; logic [PW-1:0] dpa;
    bit           perr;
    string        tag;
  } exp_t;

  exp_t sb[$];

  // Bench model of the segment registers
  longint m_reg [4];
  bit     m_perr;

  task automatic cmp(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Outcome of one access: returns paddr, sets flt
  function automatic longint predict(input bit v, input longint b, input longint lim,
                                     input longint ea, output bit flt);
    flt = 1'b0;
    if (!v) return 0;
    if (ea >= lim) begin flt = 1'b1; return 0; end
    return (b + ea) & ((64'd1 << PW) - 1);
  endfunction

  task automatic step(input bit iv, input int ia, input bit dv, input int da,
                      input bit we, input int sel, input longint wd, input bit sup,
                      input string tag);
    exp_t e;
    bit f;
    @(negedge clk);
    fetch_req = iv; fetch_ea = AW'(ia);
    data_req = dv;  data_ea = AW'(da);
    cfg_we = we; cfg_sel = 2'(sel); cfg_wdata = PW'(wd); supervisor = sup;
    e.fv = iv; e.fpa = PW'(predict(iv, m_reg[0], m_reg[1], longint'(ia), f)); e.ff = f;
    e.dv = dv; e.dpa = PW'(predict(dv, m_reg[2], m_reg[3], longint'(da), f)); e.df = f;
    if (we) begin
      if (sup) m_reg[sel] = wd & ((64'd1 << PW) - 1);
      else     m_perr = 1'b1;
    end
    e.perr = m_perr;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 1, "R2");
  endtask

  task automatic wr(input int sel, input longint v);
    step(0, 0, 0, 0, 1, sel, v, 1, "R7");
  endtask

  // Monitor: compare one expected item per cycle after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        cmp(e.tag, "fetch_rsp_valid", fetch_rsp_valid, e.fv);
        cmp(e.tag, "fetch_fault", fetch_fault, e.ff);
        cmp(e.tag, "fetch_paddr", fetch_paddr, e.fpa);
        cmp(e.tag, "data_rsp_valid", data_rsp_valid, e.dv);
        cmp(e.tag, "data_fault", data_fault, e.df);
        cmp(e.tag, "data_paddr", data_paddr, e.dpa);
        cmp(e.tag, "priv_err", priv_err, e.perr);
      end
    end
  end

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_reg[i] = 0;
    m_perr = 0;
    // R1: outputs quiet under reset, with requests applied
    fetch_req = 1; data_req = 1;
    repeat (3) @(posedge clk);
    #1;
    cmp("R1", "fetch_rsp_valid", fetch_rsp_valid, 0);
    cmp("R1", "data_rsp_valid", data_rsp_valid, 0);
    cmp("R1", "fetch_paddr", fetch_paddr, 0);
    cmp("R1", "data_fault", data_fault, 0);
    cmp("R1", "priv_err", priv_err, 0);
    @(negedge clk);
    fetch_req = 0; data_req = 0; rst_n = 1;

    // R10: unconfigured segments fault everywhere
    step(1, 0, 1, 0, 0, 0, 0, 1, "R10");
    step(1, 16'hFFFF, 1, 16'h1234, 0, 0, 0, 1, "R10");

    // R7: supervisor configuration, sel 0..3
    wr(0, 20'h10000);
    wr(1, 20'h01000);
    wr(2, 20'h20000);
    wr(3, 20'h00400);

    // R3/R5/R6: in-range translations, same address on both ports
    step(1, 16'h0123, 1, 16'h0123, 0, 0, 0, 1, "R5");
    step(1, 16'h0000, 0, 0, 0, 0, 0, 1, "R5");
    step(0, 0, 1, 16'h0001, 0, 0, 0, 1, "R6");
    // R4: boundaries length-1 and length
    step(1, 16'h0FFF, 1, 16'h03FF, 0, 0, 0, 1, "R4");
    step(1, 16'h1000, 1, 16'h0400, 0, 0, 0, 1, "R4");
    step(1, 16'h0800, 1, 16'h0800, 0, 0, 0, 1, "R4");
    idle(2);

    // R7: write in the same cycle as a request uses the old value
    step(1, 16'h0010, 1, 16'h0010, 1, 0, 20'h30000, 1, "R7");
    step(1, 16'h0010, 1, 16'h0010, 1, 3, 20'h00008, 1, "R7");
    step(1, 16'h0010, 1, 16'h0007, 0, 0, 0, 1, "R7");

    // R8: user-mode write ignored, flag raised
    step(0, 0, 1, 16'h0002, 1, 2, 20'hFFFFF, 0, "R8");
    step(1, 16'h0005, 1, 16'h0002, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 1, 1, 20'h00000, 0, "R8");
    step(1, 16'h0005, 0, 0, 0, 0, 0, 1, "R8");

    // R9: flag survives later supervisor writes
    wr(3, 20'h10000);
    idle(3);
    step(0, 0, 0, 0, 0, 0, 0, 1, "R9");

    // R3: base wraps modulo 2^PW
    wr(0, 20'hFFFF0);
    wr(1, 20'h10000);
    step(1, 16'h0020, 1, 16'hFFFF, 0, 0, 0, 1, "R3");
    step(1, 16'hFFFF, 1, 16'h0000, 0, 0, 0, 1, "R3");
    wr(2, 20'hF0001);
    step(1, 16'h0010, 1, 16'hFFFF, 0, 0, 0, 1, "R3");
    // back-to-back alternating pattern
    for (int k = 0; k < 8; k++)
      step(k[0], k * 16'h1111, ~k[0], k * 16'h0F0F, 0, 0, 0, 1, "R6");
    idle(3);
    while (sb.size() > 0) @(posedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule